// File: doc/BRIEF.md
# Tributary Clock-Loss and AIS Monitor

This block watches a single DS1 or E1 tributary on its way into a mapper. The tributary clock and data arrive as plain inputs. They are brought into a fast, free-running reference clock domain through two-flop synchronizers. Each bit is taken on the tributary clock transition picked by a static edge-select input. The block emits one output strobe per bit, together with the bit value.

Two alarms run on that stream. Loss of clock is raised when the tributary clock has not changed level for a set number of reference cycles, and it drops at the first change seen again. The alarm indication signal (AIS) alarm counts bits in fixed windows of the 3 ms length. At the end of each window it is set if the window held no more than a tolerated number of zero bits, and cleared if it held more.

While loss of clock is present, the output stream is all ones and is paced by a blue-signal clock instead of the dead tributary. The blue clock is used as it is, or divided by sixteen when a divide select is high. A registered composite flag reports that either alarm is active.

Top module: `trib_alarm_mon`

## Requirements
- R1: With `edge_sel` = 1 a bit is taken when the tributary clock goes 0 to 1; with `edge_sel` = 0 it is taken when the clock goes 1 to 0. The data value is the one present at that transition.
- R2: Without loss of clock, each sampling transition gives exactly one cycle of `out_stb` with `out_bit` equal to the sampled value. It appears on the third rising reference edge after the input change.
- R3: `loc` rises when the tributary clock has shown no level change for `LOC_LIMIT` consecutive reference cycles.
- R4: `loc` falls on the reference edge that registers the first tributary clock level change after the loss.
- R5: Bits are counted in windows of `WIN_BITS` sampled bits. When the last bit of a window is taken, `ais` becomes 1 if that window held at most `MAX_ERR` zero bits. A new window then starts.
- R6: When the last bit of a window is taken, `ais` becomes 0 if the window held more than `MAX_ERR` zero bits. `ais` changes at no other time.
- R7: `alarm_any` equals `ais` OR `loc` on every cycle after reset.
- R8: While `loc` is 1, every `out_stb` carries `out_bit` = 1, and the strobes are paced by the blue clock, not by the tributary.
- R9: With `blue_div16` = 0, one strobe is produced per rising blue clock edge. With `blue_div16` = 1, one strobe is produced per 16 rising blue clock edges.
- R10: After reset, `loc`, `ais`, `alarm_any` and `out_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low reset |
| trib_clk | input | 1 | Incoming tributary clock, asynchronous |
| trib_data | input | 1 | Incoming tributary data, asynchronous |
| edge_sel | input | 1 | 1: sample on clock rise, 0: sample on clock fall |
| blue_clk | input | 1 | Blue-signal clock, asynchronous |
| blue_div16 | input | 1 | 1: divide the blue clock by 16 |
| out_stb | output | 1 | One-cycle bit strobe toward the mapper |
| out_bit | output | 1 | Bit value qualified by `out_stb` |
| loc | output | 1 | Loss of tributary clock |
| ais | output | 1 | All-ones alarm from the window count |
| alarm_any | output | 1 | OR of `loc` and `ais` |

## Verification
A tributary clock transition reaches `out_stb`/`out_bit` on the third rising reference edge: two synchronizer flops, then the output register. The window verdict on `ais` and `alarm_any` moves on that same edge for the window's last bit, and a clock change clears `loc` on that edge too. `loc` rises `LOC_LIMIT` cycles after the detected last change. The bench drives on falling reference edges and holds every tributary bit for eight reference cycles, with the sampling transition four cycles before the bit ends, so each verdict is settled before it is read. Loss of clock is checked with margins well below and well above the limit, and strobes are counted by a monitor sampling on falling edges.

// File: rtl/trib_mon_pkg.sv
package trib_mon_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    // Indices of the asynchronous inputs inside the synchronizer bus
    localparam int unsigned IDX_TCLK  = 0;
    localparam int unsigned IDX_TDAT  = 1;
    localparam int unsigned IDX_BCLK  = 2;
    localparam int unsigned ASYNC_IN  = 3;

    typedef struct packed {
        logic stb;
        logic val;
    } bit_evt_t;

endpackage

// File: rtl/trib_mon_sync.sv
module trib_mon_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stable;
endmodule

// File: rtl/trib_mon_loc.sv
module trib_mon_loc #(
    parameter int unsigned LOC_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_edge,
    output logic loc_o,
    output logic loc_nxt_o
);
    localparam int unsigned CW = $clog2(LOC_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LOC_LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] idle;
        logic          loc;
    } loc_t;

    loc_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (any_edge) begin
            s_d.idle = '0;
            s_d.loc  = 1'b0;
        end else if (s_q.idle == LAST) begin
            s_d.loc  = 1'b1;
        end else begin
            s_d.idle = s_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign loc_o     = s_q.loc;
    assign loc_nxt_o = s_d.loc;
endmodule

// File: rtl/trib_mon_ais.sv
module trib_mon_ais #(
    parameter int unsigned WIN_BITS = 4632,
    parameter int unsigned MAX_ERR  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic bit_v,
    output logic ais_o,
    output logic ais_nxt_o,
    output logic win_end_o
);
    localparam int unsigned BW = $clog2(WIN_BITS);
    localparam int unsigned ZW = $clog2(MAX_ERR + 2);
    localparam logic [BW-1:0] BLAST = BW'(WIN_BITS - 1);
    localparam logic [ZW-1:0] ZMAX  = ZW'(MAX_ERR);
    localparam logic [ZW-1:0] ZSAT  = ZW'(MAX_ERR + 1);

    typedef struct packed {
        logic [BW-1:0] bits;
        logic [ZW-1:0] zeros;
        logic          ais;
    } ais_t;

    ais_t s_d, s_q;
    logic [ZW-1:0] zeros_upd;
    logic          last_bit;

    always_comb begin
        s_d       = s_q;
        zeros_upd = s_q.zeros;
        if (!bit_v && (s_q.zeros != ZSAT)) zeros_upd = s_q.zeros + 1'b1;
        last_bit  = stb && (s_q.bits == BLAST);
        if (last_bit) begin
            s_d.ais   = (zeros_upd <= ZMAX);
            s_d.bits  = '0;
            s_d.zeros = '0;
        end else if (stb) begin
            s_d.bits  = s_q.bits + 1'b1;
            s_d.zeros = zeros_upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ais_o     = s_q.ais;
    assign ais_nxt_o = s_d.ais;
    assign win_end_o = last_bit;
endmodule

// File: rtl/trib_mon_blue.sv
module trib_mon_blue #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blue_s,
    input  logic div_sel,
    output logic stb_o
);
    localparam int unsigned DW = $clog2(DIV);
    localparam logic [DW-1:0] DLAST = DW'(DIV - 1);

    typedef struct packed {
        logic          prev;
        logic [DW-1:0] cnt;
    } blue_t;

    blue_t s_d, s_q;
    logic  rise;

    always_comb begin
        s_d      = s_q;
        s_d.prev = blue_s;
        rise     = blue_s && !s_q.prev;
        if (div_sel) begin
            stb_o = rise && (s_q.cnt == DLAST);
            if (rise) s_d.cnt = (s_q.cnt == DLAST) ? '0 : s_q.cnt + 1'b1;
        end else begin
            stb_o = rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/trib_alarm_mon.sv
module trib_alarm_mon
    import trib_mon_pkg::*;
#(
    parameter int unsigned WIN_BITS  = 4632,
    parameter int unsigned MAX_ERR   = 8,
    parameter int unsigned LOC_LIMIT = 64,
    parameter int unsigned DIV       = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trib_clk,
    input  logic trib_data,
    input  logic edge_sel,
    input  logic blue_clk,
    input  logic blue_div16,
    output logic out_stb,
    output logic out_bit,
    output logic loc,
    output logic ais,
    output logic alarm_any
);
    typedef struct packed {
        logic     tc_prev;
        bit_evt_t out;
        logic     alarm;
    } top_t;

    top_t s_d, s_q;

    logic [ASYNC_IN-1:0] async_bus, sync_bus;
    logic     tc_s, td_s, bc_s;
    logic     any_edge, win_end, blue_stb;
    logic     loc_nxt, ais_nxt;
    bit_evt_t trib_evt;

    assign async_bus[IDX_TCLK] = trib_clk;
    assign async_bus[IDX_TDAT] = trib_data;
    assign async_bus[IDX_BCLK] = blue_clk;

    trib_mon_sync #(.W(ASYNC_IN)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(async_bus), .sync_o(sync_bus)
    );

    assign tc_s = sync_bus[IDX_TCLK];
    assign td_s = sync_bus[IDX_TDAT];
    assign bc_s = sync_bus[IDX_BCLK];

    assign any_edge     = tc_s ^ s_q.tc_prev;
    assign trib_evt.stb = edge_sel ? (tc_s && !s_q.tc_prev) : (!tc_s && s_q.tc_prev);
    assign trib_evt.val = td_s;

    trib_mon_loc #(.LOC_LIMIT(LOC_LIMIT)) u_loc (
        .clk(clk), .rst_n(rst_n), .any_edge(any_edge),
        .loc_o(loc), .loc_nxt_o(loc_nxt)
    );

    trib_mon_ais #(.WIN_BITS(WIN_BITS), .MAX_ERR(MAX_ERR)) u_ais (
        .clk(clk), .rst_n(rst_n), .stb(trib_evt.stb), .bit_v(trib_evt.val),
        .ais_o(ais), .ais_nxt_o(ais_nxt), .win_end_o(win_end)
    );

    trib_mon_blue #(.DIV(DIV)) u_blue (
        .clk(clk), .rst_n(rst_n), .blue_s(bc_s), .div_sel(blue_div16),
        .stb_o(blue_stb)
    );

    always_comb begin
        s_d         = s_q;
        s_d.tc_prev = tc_s;
        if (loc) begin
            s_d.out.stb = blue_stb;
            s_d.out.val = 1'b1;
        end else begin
            s_d.out = trib_evt;
        end
        s_d.alarm = loc_nxt | ais_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_stb   = s_q.out.stb;
    assign out_bit   = s_q.out.val;
    assign alarm_any = s_q.alarm;
endmodule

// File: rtl/trib_alarm_mon_chk.sv
module trib_alarm_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic loc,
    input logic ais,
    input logic alarm_any,
    input logic out_stb,
    input logic out_bit,
    input logic any_edge,
    input logic win_end
);
    // R7
    alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_any == (ais | loc));

    // R8
    loc_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc && out_stb) |-> out_bit);

    // R3
    loc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc) |-> !$past(any_edge));

    // R4
    loc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_edge |=> !loc);

    // R6
    ais_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(ais));
endmodule

bind trib_alarm_mon trib_alarm_mon_chk u_chk (
    .clk(clk), .rst_n(rst_n), .loc(loc), .ais(ais), .alarm_any(alarm_any),
    .out_stb(out_stb), .out_bit(out_bit), .any_edge(any_edge), .win_end(win_end)
);

// File: tb/trib_alarm_mon_test.sv
module trib_alarm_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 40;
    localparam int MERR = 8;
    localparam int LLIM = 24;

    // vector: {edge_sel, expected ais, zero count[6:0]}
    localparam int NV = 7;
    localparam logic [8:0] VEC [0:NV-1] = '{
        {1'b1, 1'b1, 7'd0},
        {1'b1, 1'b1, 7'd8},
        {1'b1, 1'b0, 7'd9},
        {1'b0, 1'b1, 7'd3},
        {1'b0, 1'b0, 7'd12},
        {1'b0, 1'b1, 7'd8},
        {1'b1, 1'b0, 7'd40}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trib_clk = 1'b0, trib_data = 1'b1, edge_sel = 1'b1;
    logic blue_clk = 1'b0, blue_div16 = 1'b0;
    logic out_stb, out_bit, loc, ais, alarm_any;

    int tests = 0, fails = 0;
    int stb_cnt = 0, ones_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trib_alarm_mon #(.WIN_BITS(WIN), .MAX_ERR(MERR), .LOC_LIMIT(LLIM), .DIV(16)) uut (
        .clk(clk), .rst_n(rst_n), .trib_clk(trib_clk), .trib_data(trib_data),
        .edge_sel(edge_sel), .blue_clk(blue_clk), .blue_div16(blue_div16),
        .out_stb(out_stb), .out_bit(out_bit), .loc(loc), .ais(ais),
        .alarm_any(alarm_any)
    );

    always @(negedge clk) begin
        if (rst_n && out_stb) begin
            stb_cnt  <= stb_cnt + 1;
            ones_cnt <= ones_cnt + int'(out_bit);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic es, input logic b);
        trib_clk = ~es;
        repeat (2) @(negedge clk);
        trib_data = b;
        repeat (2) @(negedge clk);
        trib_clk = es;
        repeat (4) @(negedge clk);
    endtask

    task automatic blue_edges(input int n);
        for (int i = 0; i < n; i++) begin
            blue_clk = 1'b1;
            repeat (3) @(negedge clk);
            blue_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int s0, o0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10 reset state
        chk("R10 loc", int'(loc), 0);
        chk("R10 ais", int'(ais), 0);
        chk("R10 alarm_any", int'(alarm_any), 0);
        chk("R10 out_stb count", stb_cnt, 0);

        // table walk: R1 R2 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            logic es, exp_ais;
            int   nz;
            es      = VEC[v][8];
            exp_ais = VEC[v][7];
            nz      = int'(VEC[v][6:0]);
            edge_sel = es;
            s0 = stb_cnt;
            o0 = ones_cnt;
            for (int i = 0; i < WIN; i++) send_bit(es, (i < nz) ? 1'b0 : 1'b1);
            chk("R2 strobes per window", stb_cnt - s0, WIN);
            chk("R1 ones per window", ones_cnt - o0, WIN - nz);
            chk(exp_ais ? "R5 ais set" : "R6 ais clear", int'(ais), int'(exp_ais));
            chk("R7 alarm_any", int'(alarm_any), int'(exp_ais));
        end

        // loss of clock: R3 R7 R8
        repeat (10) @(negedge clk);
        chk("R3 loc before limit", int'(loc), 0);
        repeat (30) @(negedge clk);
        chk("R3 loc after limit", int'(loc), 1);
        chk("R7 alarm_any with loc", int'(alarm_any), 1);
        chk("R6 ais unchanged during loc", int'(ais), 0);

        // blue path undivided: R9 R8
        blue_div16 = 1'b0;
        s0 = stb_cnt;
        o0 = ones_cnt;
        blue_edges(32);
        chk("R9 undivided strobes", stb_cnt - s0, 32);
        chk("R8 all ones undivided", ones_cnt - o0, 32);

        // blue path divided: R9 R8
        blue_div16 = 1'b1;
        s0 = stb_cnt;
        o0 = ones_cnt;
        blue_edges(48);
        chk("R9 divided strobes", stb_cnt - s0, 3);
        chk("R8 all ones divided", ones_cnt - o0, 3);

        // clock returns: R4 R7
        trib_clk = ~trib_clk;
        repeat (5) @(negedge clk);
        chk("R4 loc cleared", int'(loc), 0);
        chk("R7 alarm_any cleared", int'(alarm_any), 0);

        finish_run();
    end
endmodule